// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a small microcontroller core. It has four levels, each holding one 11-bit program-counter value, and a private pointer. No data or program address reaches the levels or the pointer. The core strobes `push_i` with the current PC when it takes a subroutine call or acknowledges an interrupt. It strobes `pop_i` on a return or a return-from-interrupt, and it takes the restored PC from `pc_o` in that same cycle.

Interrupt overflow is prevented at the source. While all four levels are in use, the acknowledge-enable output stays low even if an interrupt is pending, so the request waits. Once a return frees a level, the output rises and the waiting interrupt can be taken. An explicit call on a full stack is not blocked. The storage wraps around, the oldest return address is overwritten, and the four newest are kept.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack is empty, `pc_o` reads 0, and `irq_ack_en_o` follows `irq_pending_i`.
- R2: A push alone (`push_i`=1, `pop_i`=0) makes `pc_o` show the pushed `pc_i` value from the next cycle on.
- R3: A pop alone on a non-empty stack drops the newest entry, and `pc_o` then shows the entry pushed before it (last-in, first-out).
- R4: Up to four pushed values are kept unchanged while neither strobe is active.
- R5: While four levels are in use, `irq_ack_en_o` is 0 even when `irq_pending_i` is 1.
- R6: `irq_ack_en_o` is 1 whenever `irq_pending_i` is 1 and fewer than four levels are in use, including the cycle after a pop from a full stack.
- R7: A push on a full stack overwrites the oldest entry. The level count stays at four, and the four most recent values pop out newest first.
- R8: A pop on an empty stack changes nothing: `pc_o` keeps its value and the level count stays at 0.
- R9: A push and a pop in the same cycle are ignored: `pc_o` and the level count are unchanged.
- R10: `irq_ack_en_o` is 0 whenever `irq_pending_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Save `pc_i` (call or interrupt acknowledge) |
| pop_i | input | 1 | Restore the newest entry (return) |
| pc_i | input | 11 | Return address to save |
| irq_pending_i | input | 1 | An unmasked interrupt is waiting |
| pc_o | output | 11 | Newest saved return address |
| irq_ack_en_o | output | 1 | The pending interrupt may be acknowledged |

## Verification
Two cases can fall in one cycle: a push and a pop, and an interrupt arriving while the stack is full. The bench drives both strobes at once, first in a directed step and then at random among pushes and pops, and it expects `pc_o` and the level count to stay as they were. It also holds `irq_pending_i` high while filling the stack, overflowing it with a call and draining it. It then compares `irq_ack_en_o` in every cycle with a model that grants only below four levels.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLASH = 2'd3
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    case ({push, pop})
      2'b10:   return OP_PUSH;
      2'b01:   return OP_POP;
      2'b11:   return OP_CLASH;
      default: return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(DEPTH);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_en;
  stk_op_e          op;

  function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_dec(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  assign op = decode_op(push_i, pop_i);

  // next-state
  always_comb begin
    idx_d = idx_q;
    cnt_d = cnt_q;
    st_en = 1'b0;
    case (op)
      OP_PUSH: begin
        st_en = 1'b1;
        idx_d = idx_inc(idx_q);
        if (cnt_q != MAX_CNT) cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        if (cnt_q != '0) begin
          st_en = 1'b1;
          idx_d = idx_dec(idx_q);
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_en = 1'b0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (st_en) begin
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_en_o  = (op == OP_PUSH);
  assign wr_idx_o = idx_q;
  assign rd_idx_o = idx_dec(idx_q);
  assign level_o  = cnt_q;
  assign full_o   = (cnt_q == MAX_CNT);

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 11,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_data_o
);

  logic [DEPTH-1:0][PC_W-1:0] slots;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic             ld;
    logic [PC_W-1:0]  ent_q;

    assign ld = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= '0;
      else if (ld) ent_q <= wr_data_i;
    end

    assign slots[g] = ent_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_idx_i == IDX_W'(k)) rd_data_o = slots[k];
    end
  end

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            irq_pending_i,
  output logic [PC_W-1:0] pc_o,
  output logic            irq_ack_en_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] level;
  logic             full;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx),
    .level_o  (level),
    .full_o   (full)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (pc_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pc_o)
  );

  assign irq_ack_en_o = irq_pending_i & ~full;

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 11,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_i,
  input logic            pop_i,
  input logic [PC_W-1:0] pc_i,
  input logic            irq_pending_i,
  input logic [PC_W-1:0] pc_o,
  input logic            irq_ack_en_o,
  input logic [CNT_W-1:0] level
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (pc_o == $past(pc_i)));

  assert_pop_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && level != '0) |=> (level == $past(level) - 1'b1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> ($stable(pc_o) && $stable(level)));

  assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == MAX_CNT) |-> !irq_ack_en_o);

  assert_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending_i && level < MAX_CNT) |-> irq_ack_en_o);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && level == MAX_CNT) |=> (level == MAX_CNT));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && level == '0) |=> ($stable(pc_o) && level == '0));

  assert_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> ($stable(pc_o) && $stable(level)));

  assert_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending_i |-> !irq_ack_en_o);

endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .pc_i          (pc_i),
  .irq_pending_i (irq_pending_i),
  .pc_o          (pc_o),
  .irq_ack_en_o  (irq_ack_en_o),
  .level         (level)
);

// File: tb/ret_stack_tb.sv
module ret_stack_tb;

  localparam int DEPTH = 4;
  localparam int PC_W  = 11;

  logic            clk;
  logic            rst_n;
  logic            push_i;
  logic            pop_i;
  logic [PC_W-1:0] pc_i;
  logic            irq_pending_i;
  logic [PC_W-1:0] pc_o;
  logic            irq_ack_en_o;

  int checks;
  int errors;
  bit done;

  // bench model
  logic [PC_W-1:0] m_slot [DEPTH];
  int              m_idx;
  int              m_cnt;

  ret_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_i        (push_i),
    .pop_i         (pop_i),
    .pc_i          (pc_i),
    .irq_pending_i (irq_pending_i),
    .pc_o          (pc_o),
    .irq_ack_en_o  (irq_ack_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [PC_W-1:0] model_top();
    return m_slot[(m_idx + DEPTH - 1) % DEPTH];
  endfunction

  function automatic logic model_ack(input logic pend);
    return pend && (m_cnt < DEPTH);
  endfunction

  function automatic void model_step(input logic psh, input logic pp, input logic [PC_W-1:0] d);
    if (psh && !pp) begin
      m_slot[m_idx] = d;
      m_idx = (m_idx + 1) % DEPTH;
      if (m_cnt < DEPTH) m_cnt = m_cnt + 1;
    end else if (pp && !psh && m_cnt > 0) begin
      m_idx = (m_idx + DEPTH - 1) % DEPTH;
      m_cnt = m_cnt - 1;
    end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check grant, clock, check top of stack
  task automatic do_op(input logic psh, input logic pp, input logic [PC_W-1:0] d, input logic pend);
    string tg;
    logic  ex_ack;
    @(negedge clk);
    push_i = psh; pop_i = pp; pc_i = d; irq_pending_i = pend;
    #1;
    ex_ack = model_ack(pend);
    if (!pend)            tg = "R10";
    else if (m_cnt == DEPTH) tg = "R5";
    else                  tg = "R6";
    check(irq_ack_en_o == ex_ack, tg, int'(irq_ack_en_o), int'(ex_ack));
    if (psh && pp)             tg = "R9";
    else if (psh && m_cnt == DEPTH) tg = "R7";
    else if (psh)              tg = "R2";
    else if (pp && m_cnt == 0) tg = "R8";
    else if (pp)               tg = "R3";
    else                       tg = "R4";
    model_step(psh, pp, d);
    @(posedge clk);
    #1;
    check(pc_o == model_top(), tg, int'(pc_o), int'(model_top()));
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
    m_idx = 0; m_cnt = 0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; pc_i = '0; irq_pending_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pc_o == '0, "R1", int'(pc_o), 0);
    check(irq_ack_en_o == 1'b1, "R1", int'(irq_ack_en_o), 1);

    // R8: pop on empty right after reset
    do_op(1'b0, 1'b1, 11'h000, 1'b1);
    // R2/R5: fill to four levels with an interrupt pending
    do_op(1'b1, 1'b0, 11'h101, 1'b1);
    do_op(1'b1, 1'b0, 11'h202, 1'b1);
    do_op(1'b1, 1'b0, 11'h303, 1'b1);
    do_op(1'b1, 1'b0, 11'h404, 1'b1);
    // R4: idle with full stack, grant held off (R5)
    do_op(1'b0, 1'b0, 11'h7FF, 1'b1);
    // R9: clash on full stack
    do_op(1'b1, 1'b1, 11'h555, 1'b1);
    // R7: call on full overwrites oldest
    do_op(1'b1, 1'b0, 11'h505, 1'b1);
    // R3/R6: drain, grant returns after first pop
    do_op(1'b0, 1'b1, 11'h000, 1'b1);
    do_op(1'b0, 1'b0, 11'h000, 1'b1);
    do_op(1'b0, 1'b1, 11'h000, 1'b1);
    do_op(1'b0, 1'b1, 11'h000, 1'b0);
    do_op(1'b0, 1'b1, 11'h000, 1'b1);
    // R8: pop on empty after draining
    do_op(1'b0, 1'b1, 11'h000, 1'b1);
    // R9: clash on empty stack
    do_op(1'b1, 1'b1, 11'h0AA, 1'b0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic psh, pp;
      r = int'($urandom % 8);
      psh = (r < 3) || (r == 7);
      pp  = (r >= 3 && r < 6) || (r == 7);
      do_op(psh, pp, PC_W'($urandom), logic'($urandom % 2));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule